// File: doc/BRIEF.md
# Multicast Spike Packet Router

This block steers 40-bit spike packets through one node of a six-neighbour mesh. Each cycle it can take one packet from a serialized input stream. The input carries a source code that names the arrival link or marks a packet made by a local core. Multicast packets look up their 32-bit routing key in a masked associative table. A hit returns a 26-bit destination set: 20 local core ports and 6 link ports. A multicast packet that misses the table and arrived on a link goes out on the opposite link. A local packet that misses is discarded, and a sticky error flag is raised. Nearest-neighbour packets go out on all six links.

A packet is held in an output register while its destinations accept it. Each destination bit clears when its ready is high. A new packet is accepted in the same cycle that the last pending bit is taken. Sometimes the only remaining destination is one link that stays blocked for longer than a programmable limit. The router then moves the packet to the next link around the node and waits there.

The control is a three-state machine. `ST_IDLE` holds no packet. `ST_SEND` is delivering a packet. `ST_EMERG` is delivering a diverted packet. The transitions are:
- accept a routed packet: `ST_IDLE` to `ST_SEND`, or `ST_SEND` to `ST_SEND`;
- last bit taken with no new packet: `ST_SEND` or `ST_EMERG` to `ST_IDLE`;
- stall limit reached: `ST_SEND` to `ST_EMERG`;
- discard: any state to `ST_IDLE`.

Top module: `mc_router`

## Requirements
- R1: After reset `out_valid` is all zero, `in_ready` is 1 and `err_local` is 0.
- R2: Bit 39 of the packet selects the kind: 0 is multicast, 1 is nearest-neighbour. Bits 31:0 are the routing key. Entry e hits when it is valid and (key & mask_e) == key_e. A hit sends the packet to every output set in that entry's route vector. Bits 19:0 of the vector are core ports and bits 25:20 are links 0 to 5.
- R3: When several entries hit, the entry with the lowest index supplies the route.
- R4: A multicast miss that arrived on link i (`in_src` 0 to 5) is sent only on link (i+3) mod 6.
- R5: A multicast miss with `in_src` 6 or 7 (local) is accepted and produces no output. It sets `err_local`, which stays 1 until reset.
- R6: A nearest-neighbour packet is sent on all six links and on no core port, whatever the table holds.
- R7: When every output is ready, a packet is accepted on each clock. Each packet appears on the outputs on the cycle after its acceptance.
- R8: A packet stays on `out_pkt` until every destination has taken it. Each `out_valid` bit drops after its ready is seen. `in_ready` is 0 while any destination is still untaken.
- R9: Suppose the only untaken destination is link j and it stays not ready. With `stall_limit` = W, the packet is shown on link j for W+1 cycles and then only on link (j+1) mod 6.
- R10: A table write takes effect on the next cycle. An entry written with its valid bit 0 never hits. Rewriting an entry replaces its route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input packet present |
| in_src | input | 3 | Arrival link 0 to 5, or 6 or 7 for a local core |
| in_pkt | input | 40 | Input packet |
| in_ready | output | 1 | Router takes the input this cycle |
| out_valid | output | 26 | Pending destinations: cores 19:0, links 25:20 |
| out_pkt | output | 40 | Packet being delivered |
| out_ready | input | 26 | Per-destination accept |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 10 | Entry to write |
| tbl_key | input | 32 | Entry key |
| tbl_mask | input | 32 | Entry mask |
| tbl_route | input | 26 | Entry destination vector |
| tbl_vld | input | 1 | Entry valid bit |
| stall_limit | input | 8 | Cycles of stall before diversion |
| err_local | output | 1 | Sticky flag for a discarded local packet |

## Verification
A packet accepted at one rising edge shows its destinations on `out_valid` from that edge onward. The error flag is also set at that same edge. The bench drives inputs and samples every result at the falling edge that follows. A diversion is due W+1 falling edges after the packet first appears, so the bench checks the link one edge before that point and again at it. A scoreboard queue receives one expected item for each routed packet, and the monitor pops an item for each cycle in which an output is valid.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
    localparam int PKT_W   = 40;
    localparam int KEY_W   = 32;
    localparam int N_LINKS = 6;
    localparam int NN_BIT  = 39;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_EMERG = 2'd2
    } rt_state_e;
endpackage

// File: rtl/rt_table.sv
module rt_table
    import mcr_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int VEC_W = 26,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [KEY_W-1:0] wkey,
    input  logic [KEY_W-1:0] wmask,
    input  logic [VEC_W-1:0] wroute,
    input  logic             wvld,
    input  logic [KEY_W-1:0] lkey,
    output logic             hit,
    output logic [VEC_W-1:0] hroute
);
    logic [KEY_W-1:0] key_q   [DEPTH];
    logic [KEY_W-1:0] mask_q  [DEPTH];
    logic [VEC_W-1:0] route_q [DEPTH];
    logic [DEPTH-1:0] vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (we) begin
            vld_q[widx] <= wvld;
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            key_q[widx]   <= wkey;
            mask_q[widx]  <= wmask;
            route_q[widx] <= wroute;
        end
    end

    // Scan from the top so the lowest matching index is the one left standing.
    always_comb begin
        hit    = 1'b0;
        hroute = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vld_q[i] && ((lkey & mask_q[i]) == key_q[i])) begin
                hit    = 1'b1;
                hroute = route_q[i];
            end
        end
    end
endmodule

// File: rtl/rt_dest.sv
module rt_dest
    import mcr_pkg::*;
#(
    parameter int N_CORES = 20,
    localparam int VEC_W = N_CORES + N_LINKS
) (
    input  logic             is_nn,
    input  logic [2:0]       src,
    input  logic             hit,
    input  logic [VEC_W-1:0] hroute,
    output logic [VEC_W-1:0] vec,
    output logic             drop
);
    int opp_link;

    always_comb begin
        vec      = '0;
        drop     = 1'b0;
        opp_link = (int'(src) + 3) % N_LINKS;
        if (is_nn) begin
            vec[VEC_W-1 -: N_LINKS] = '1;
        end else if (hit) begin
            vec = hroute;
        end else if (src < 3'(N_LINKS)) begin
            vec[N_CORES + opp_link] = 1'b1;
        end else begin
            drop = 1'b1;
        end
    end
endmodule

// File: rtl/rt_fsm.sv
module rt_fsm
    import mcr_pkg::*;
#(
    parameter int N_CORES = 20,
    parameter int CNT_W   = 8,
    localparam int VEC_W = N_CORES + N_LINKS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] new_vec,
    input  logic [PKT_W-1:0] new_pkt,
    input  logic             new_drop,
    input  logic [CNT_W-1:0] wait_lim,
    input  logic [VEC_W-1:0] out_ready,
    output logic             in_ready,
    output logic [VEC_W-1:0] out_valid,
    output logic [PKT_W-1:0] out_pkt,
    output logic             err_o
);
    rt_state_e          st_q, st_d;
    logic [VEC_W-1:0]   pend_q, pend_d, remain;
    logic [PKT_W-1:0]   pkt_q, pkt_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic               err_q, err_d, take, link_only;
    logic [N_LINKS-1:0] lnk, rot;

    assign remain    = pend_q & ~out_ready;
    assign link_only = (remain[N_CORES-1:0] == '0) && $onehot(remain);
    assign lnk       = remain[VEC_W-1:N_CORES];
    assign rot       = {lnk[N_LINKS-2:0], lnk[N_LINKS-1]};
    assign take      = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            pend_q <= '0;
            pkt_q  <= '0;
            cnt_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            pend_q <= pend_d;
            pkt_q  <= pkt_d;
            cnt_q  <= cnt_d;
            err_q  <= err_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        pend_d = pend_q;
        pkt_d  = pkt_q;
        cnt_d  = cnt_q;
        err_d  = err_q;
        unique case (st_q)
            ST_IDLE: begin
            end
            ST_SEND: begin
                pend_d = remain;
                if (remain == '0) begin
                    st_d = ST_IDLE;
                end else if (link_only) begin
                    if (cnt_q == wait_lim) begin
                        pend_d = {rot, {N_CORES{1'b0}}};
                        st_d   = ST_EMERG;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_EMERG: begin
                pend_d = remain;
                if (remain == '0) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
        if (take) begin
            pkt_d = new_pkt;
            cnt_d = '0;
            if (new_drop) begin
                err_d  = 1'b1;
                pend_d = '0;
                st_d   = ST_IDLE;
            end else begin
                pend_d = new_vec;
                st_d   = (new_vec == '0) ? ST_IDLE : ST_SEND;
            end
        end
    end

    always_comb begin
        in_ready  = (st_q == ST_IDLE) || (remain == '0);
        out_valid = pend_q;
        out_pkt   = pkt_q;
        err_o     = err_q;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (out_valid == '0));
    // R8
    pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(out_pkt));
    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);
    // R9
    emerg_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EMERG) |-> ($countones(out_valid) <= 1 && out_valid[N_CORES-1:0] == '0));
endmodule

// File: rtl/mc_router.sv
module mc_router
    import mcr_pkg::*;
#(
    parameter int N_CORES = 20,
    parameter int DEPTH   = 1024,
    parameter int CNT_W   = 8,
    localparam int VEC_W = N_CORES + N_LINKS,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [2:0]       in_src,
    input  logic [PKT_W-1:0] in_pkt,
    output logic             in_ready,
    output logic [VEC_W-1:0] out_valid,
    output logic [PKT_W-1:0] out_pkt,
    input  logic [VEC_W-1:0] out_ready,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_idx,
    input  logic [KEY_W-1:0] tbl_key,
    input  logic [KEY_W-1:0] tbl_mask,
    input  logic [VEC_W-1:0] tbl_route,
    input  logic             tbl_vld,
    input  logic [CNT_W-1:0] stall_limit,
    output logic             err_local
);
    logic             hit, drop;
    logic [VEC_W-1:0] hroute, vec;

    rt_table #(.DEPTH(DEPTH), .VEC_W(VEC_W)) u_table (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_idx),
        .wkey(tbl_key), .wmask(tbl_mask), .wroute(tbl_route), .wvld(tbl_vld),
        .lkey(in_pkt[KEY_W-1:0]), .hit(hit), .hroute(hroute)
    );

    rt_dest #(.N_CORES(N_CORES)) u_dest (
        .is_nn(in_pkt[NN_BIT]), .src(in_src), .hit(hit), .hroute(hroute),
        .vec(vec), .drop(drop)
    );

    rt_fsm #(.N_CORES(N_CORES), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .new_vec(vec),
        .new_pkt(in_pkt), .new_drop(drop), .wait_lim(stall_limit),
        .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
        .out_pkt(out_pkt), .err_o(err_local)
    );

    // R6
    nn_bcast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_pkt[NN_BIT]) |=>
        (out_valid[VEC_W-1 -: N_LINKS] == '1 && out_valid[N_CORES-1:0] == '0));
    // R7
    accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_pkt == $past(in_pkt)));
endmodule

// File: tb/mc_router_bench.sv
`timescale 1ns/1ps
module mc_router_bench;
    localparam int VW = 26;

    typedef struct {
        logic [VW-1:0] vec;
        logic [39:0]   pkt;
        string         tag;
    } exp_t;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          in_valid = 1'b0, tbl_we = 1'b0, tbl_vld = 1'b0;
    logic [2:0]    in_src = '0;
    logic [39:0]   in_pkt = '0, out_pkt;
    logic          in_ready, err_local;
    logic [VW-1:0] out_valid, out_ready = '1, tbl_route = '0;
    logic [9:0]    tbl_idx = '0;
    logic [31:0]   tbl_key = '0, tbl_mask = '0;
    logic [7:0]    stall_limit = 8'd200;

    int   total = 0, bad = 0, stalls = 0;
    bit   mon_en = 1'b0;
    exp_t q[$];

    always #2.5 clk = ~clk;

    mc_router u_mc_router (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_src(in_src),
        .in_pkt(in_pkt), .in_ready(in_ready), .out_valid(out_valid),
        .out_pkt(out_pkt), .out_ready(out_ready), .tbl_we(tbl_we),
        .tbl_idx(tbl_idx), .tbl_key(tbl_key), .tbl_mask(tbl_mask),
        .tbl_route(tbl_route), .tbl_vld(tbl_vld), .stall_limit(stall_limit),
        .err_local(err_local)
    );

    function automatic logic [VW-1:0] lk(int i);
        return VW'(1) << (20 + i);
    endfunction
    function automatic logic [VW-1:0] cr(int i);
        return VW'(1) << i;
    endfunction
    function automatic logic [39:0] mc(logic [31:0] k);
        return {8'h00, k};
    endfunction
    function automatic logic [39:0] nn(logic [31:0] k);
        return {8'h80, k};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [31:0] k, logic [31:0] m, logic [VW-1:0] r, logic v);
        tbl_we = 1'b1; tbl_idx = 10'(idx); tbl_key = k; tbl_mask = m;
        tbl_route = r; tbl_vld = v;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic send(logic [2:0] s, logic [39:0] p, logic [VW-1:0] e, string tag);
        if (e != '0) q.push_back('{vec: e, pkt: p, tag: tag});
        in_valid = 1'b1; in_src = s; in_pkt = p;
        #1;
        while (!in_ready) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (mon_en && out_valid != '0) begin
            if (q.size() == 0) begin
                chk("R7 unexpected output", 64'(out_valid), 64'h0);
            end else begin
                exp_t x;
                x = q.pop_front();
                chk({x.tag, " vec"}, 64'(out_valid), 64'(x.vec));
                chk({x.tag, " pkt"}, 64'(out_pkt), 64'(x.pkt));
            end
        end
    end

    initial begin
        #(200000 * 5);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 out_valid", 64'(out_valid), 64'h0);
        chk("R1 in_ready", 64'(in_ready), 64'h1);
        chk("R1 err_local", 64'(err_local), 64'h0);

        wr(0, 32'h0001_2300, 32'hFFFF_FF00, cr(1) | cr(7) | lk(4), 1'b1);
        wr(3, 32'h0001_0000, 32'hFFFF_0000, cr(9), 1'b1);
        wr(6, 32'hABCD_0000, 32'hFFFF_FFFF, cr(2), 1'b0);
        wr(8, 32'hABCD_0000, 32'hFFFF_FFFF, cr(5) | lk(0), 1'b1);

        mon_en = 1'b1;
        stalls = 0;
        send(3'd6, mc(32'h0001_23AB), cr(1) | cr(7) | lk(4), "R2 R3 lowest hit");
        send(3'd1, mc(32'h0001_5555), cr(9), "R2 masked hit");
        send(3'd2, mc(32'hABCD_0000), cr(5) | lk(0), "R10 invalid skipped");
        send(3'd0, mc(32'h5555_5555), lk(3), "R4 miss link0");
        send(3'd4, mc(32'h5555_5555), lk(1), "R4 miss link4");
        send(3'd5, mc(32'h5555_5555), lk(2), "R4 miss link5");
        send(3'd6, nn(32'h0001_23AB), lk(0) | lk(1) | lk(2) | lk(3) | lk(4) | lk(5), "R6 nn local");
        send(3'd3, nn(32'h1234_0000), lk(0) | lk(1) | lk(2) | lk(3) | lk(4) | lk(5), "R6 nn link");
        // R7 back to back with no stall
        chk("R7 stalls", 64'(stalls), 64'h0);

        send(3'd7, mc(32'h7777_7777), '0, "R5");
        chk("R5 err_local set", 64'(err_local), 64'h1);
        chk("R5 no output", 64'(out_valid), 64'h0);

        wr(8, 32'hABCD_0000, 32'hFFFF_FFFF, cr(19), 1'b1);
        send(3'd2, mc(32'hABCD_0000), cr(19), "R10 rewrite");
        repeat (3) @(negedge clk);
        mon_en = 1'b0;
        chk("R7 queue drained", 64'(q.size()), 64'h0);

        // R8 partial delivery
        wr(10, 32'h00C0_FFEE, 32'hFFFF_FFFF, cr(3) | lk(1), 1'b1);
        out_ready = ~lk(1);
        send(3'd7, mc(32'h00C0_FFEE), '0, "R8");
        chk("R8 both pending", 64'(out_valid), 64'(cr(3) | lk(1)));
        #1;
        chk("R8 in_ready low", 64'(in_ready), 64'h0);
        @(negedge clk);
        chk("R8 core bit cleared", 64'(out_valid), 64'(lk(1)));
        chk("R8 pkt held", 64'(out_pkt), 64'(mc(32'h00C0_FFEE)));
        out_ready = '1;
        @(negedge clk);
        chk("R8 done", 64'(out_valid), 64'h0);
        chk("R5 err sticky", 64'(err_local), 64'h1);

        // R9 emergency diversion, W = 3
        stall_limit = 8'd3;
        out_ready = ~lk(5);
        send(3'd2, mc(32'h1212_1212), '0, "R9");
        chk("R9 primary first", 64'(out_valid), 64'(lk(5)));
        repeat (3) @(negedge clk);
        chk("R9 primary at W+1", 64'(out_valid), 64'(lk(5)));
        @(negedge clk);
        chk("R9 diverted", 64'(out_valid), 64'(lk(0)));
        chk("R9 pkt kept", 64'(out_pkt), 64'(mc(32'h1212_1212)));
        out_ready = '1;
        @(negedge clk);
        chk("R9 delivered", 64'(out_valid), 64'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule